// File: doc/BRIEF.md
# Two-Channel Chained DMA Sequencer

This block is a compact DMA engine with two logical channels that share a single mover. Each channel copies 16-bit elements from a source region to a destination region. Its programmed values are a start source address, a start destination address, a number of elements per frame, a number of frames, and a mode bit. In frame mode the channel moves one frame per request and then waits. In block mode one start moves every frame back to back. Both addresses advance by two bytes per element. They reload from their programmed values each time the channel starts again.

A channel can trigger the other channel, or itself, when it finishes servicing a request. The timing of that trigger depends on the mode. In frame mode it fires after every frame. In block mode it fires only after the last frame. Because of this, a chained channel can run with no software action after the first start. Each channel keeps a sticky block-complete flag that is cleared by writing a one. The flag drives a per-channel level interrupt through an enable bit. The memory side is a plain synchronous port: the read data returns one cycle after the read enable, and writes take effect at the clock edge.

Top module: `dual_chain_dma`

## Requirements
- R1: In block mode, one start copies frames x elements 16-bit words, in order, from the source start address to the destination start address. Byte addresses step by 2 per element, and nothing is written past the last element.
- R2: In frame mode the start moves the first frame. After that, each `hw_req` pulse while the channel is busy moves exactly one further frame, continuing at the following addresses. A `hw_req` on an idle channel has no effect.
- R3: The block-complete flag of a channel is set once the last element of its last frame has been written. It stays set until its `flag_clr` bit is pulsed, even across a new start. `irq[c]` equals the flag AND `cfg_irq_en[c]`.
- R4: With chaining enabled in frame mode, the target channel is started after every frame of the source channel.
- R5: With chaining enabled in block mode, the target channel is started only after the whole block is done. None of the target's writes comes before the source's last write.
- R6: A start, whether from software or from a chain trigger, is ignored while the channel is busy. In that case its addresses are not reloaded.
- R7: A new start of an idle channel reloads both addresses from their programmed start values.
- R8: When both channels are pending, channel 0 is served first. A frame already in progress is never interrupted by the other channel.
- R9: A frame count or element count of zero writes nothing. It sets the block-complete flag at once and still fires the chain trigger.
- R10: Every write carries the data of the read issued in the previous cycle. A read and a write never occur in the same cycle.
- R11: `busy[c]` is high from the cycle after an accepted start until the last frame of the channel finishes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_src | input | 2x16 | Per-channel source start byte address |
| cfg_dst | input | 2x16 | Per-channel destination start byte address |
| cfg_ecnt | input | 2x8 | Per-channel elements per frame |
| cfg_fcnt | input | 2x8 | Per-channel frames per block |
| cfg_block | input | 2 | 1 = block mode, 0 = frame mode |
| cfg_chain_en | input | 2 | Enable chain trigger from this channel |
| cfg_chain_tgt | input | 2x1 | Index of the channel to trigger |
| cfg_irq_en | input | 2 | Interrupt enable per channel |
| sw_start | input | 2 | Software start pulse per channel |
| hw_req | input | 2 | Hardware frame request per channel |
| flag_clr | input | 2 | Write-one-to-clear for block-complete flags |
| blk_done | output | 2 | Block-complete flags |
| irq | output | 2 | Level interrupt per channel |
| busy | output | 2 | Channel active |
| mem_rd_en | output | 1 | Memory read enable |
| mem_rd_addr | output | 16 | Memory read byte address |
| mem_rd_data | input | 16 | Read data, valid one cycle after mem_rd_en |
| mem_wr_en | output | 1 | Memory write enable |
| mem_wr_addr | output | 16 | Memory write byte address |
| mem_wr_data | output | 16 | Memory write data |

## Verification
The assertions take for granted that the memory returns read data exactly one cycle after a read enable. They also assume that a channel's configuration is held steady while that channel is busy, since the mover samples the element count at grant time and the channel samples its mode at every frame end. The stimulus changes configuration only after it has observed both channels idle for several consecutive cycles, and its memory model has a fixed one-cycle read latency. Flag clears are issued only while the channels are idle.

// File: rtl/dcd_pkg.sv
package dcd_pkg;
    localparam int ELEM_BYTES = 2;

    typedef enum logic [1:0] {
        MV_IDLE  = 2'd0,
        MV_READ  = 2'd1,
        MV_WRITE = 2'd2
    } mv_state_t;
endpackage

// File: rtl/dcd_chan.sv
module dcd_chan #(
    parameter int AW = 16,
    parameter int EW = 8,
    parameter int FW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          hw_req,
    input  logic          flag_clr,
    input  logic [AW-1:0] cfg_src,
    input  logic [AW-1:0] cfg_dst,
    input  logic [EW-1:0] cfg_ecnt,
    input  logic [FW-1:0] cfg_fcnt,
    input  logic          cfg_block,
    input  logic          frame_done,
    input  logic [AW-1:0] upd_src,
    input  logic [AW-1:0] upd_dst,
    output logic          active,
    output logic          pend,
    output logic [AW-1:0] cur_src,
    output logic [AW-1:0] cur_dst,
    output logic          done_flag,
    output logic          chain_fire
);
    logic [FW-1:0] frames_left;
    logic          empty_job;
    logic          last_frame;

    assign empty_job  = (cfg_ecnt == '0) || (cfg_fcnt == '0);
    assign last_frame = (frames_left == FW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            active      <= 1'b0;
            pend        <= 1'b0;
            cur_src     <= '0;
            cur_dst     <= '0;
            frames_left <= '0;
            done_flag   <= 1'b0;
            chain_fire  <= 1'b0;
        end else begin
            chain_fire <= 1'b0;
            if (flag_clr) done_flag <= 1'b0;
            if (start && !active) begin
                cur_src <= cfg_src;
                cur_dst <= cfg_dst;
                if (empty_job) begin
                    done_flag  <= 1'b1;
                    chain_fire <= 1'b1;
                end else begin
                    active      <= 1'b1;
                    pend        <= 1'b1;
                    frames_left <= cfg_fcnt;
                end
            end else if (active) begin
                if (frame_done) begin
                    cur_src     <= upd_src;
                    cur_dst     <= upd_dst;
                    frames_left <= frames_left - FW'(1);
                    chain_fire  <= !cfg_block || last_frame;
                    if (last_frame) begin
                        active    <= 1'b0;
                        pend      <= 1'b0;
                        done_flag <= 1'b1;
                    end else if (!cfg_block) begin
                        pend <= hw_req;
                    end
                end else if (hw_req) begin
                    pend <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/dcd_arb.sv
module dcd_arb #(
    parameter int NCH = 2,
    parameter int CIW = 1
) (
    input  logic [NCH-1:0] pend,
    output logic           gnt_valid,
    output logic [CIW-1:0] gnt_idx
);
    always_comb begin
        gnt_valid = 1'b0;
        gnt_idx   = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (pend[i]) begin
                gnt_valid = 1'b1;
                gnt_idx   = CIW'(i);
            end
        end
    end
endmodule

// File: rtl/dcd_mover.sv
module dcd_mover
    import dcd_pkg::*;
#(
    parameter int AW  = 16,
    parameter int EW  = 8,
    parameter int CIW = 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic [CIW-1:0] ld_ch,
    input  logic [AW-1:0]  ld_src,
    input  logic [AW-1:0]  ld_dst,
    input  logic [EW-1:0]  ld_ecnt,
    output logic           idle,
    output logic           frame_done,
    output logic [CIW-1:0] cur_ch,
    output logic [AW-1:0]  nxt_src,
    output logic [AW-1:0]  nxt_dst,
    output logic           mem_rd_en,
    output logic [AW-1:0]  mem_rd_addr,
    input  logic [15:0]    mem_rd_data,
    output logic           mem_wr_en,
    output logic [AW-1:0]  mem_wr_addr,
    output logic [15:0]    mem_wr_data
);
    typedef struct packed {
        logic [CIW-1:0] ch;
        logic [AW-1:0]  src;
        logic [AW-1:0]  dst;
        logic [EW-1:0]  left;
    } job_t;

    localparam logic [AW-1:0] STEP = AW'(ELEM_BYTES);

    mv_state_t state;
    job_t      job;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= MV_IDLE;
            job   <= '0;
        end else begin
            unique case (state)
                MV_IDLE: if (load) begin
                    job.ch   <= ld_ch;
                    job.src  <= ld_src;
                    job.dst  <= ld_dst;
                    job.left <= ld_ecnt;
                    state    <= MV_READ;
                end
                MV_READ: begin
                    job.src <= job.src + STEP;
                    state   <= MV_WRITE;
                end
                MV_WRITE: begin
                    job.dst  <= job.dst + STEP;
                    job.left <= job.left - EW'(1);
                    state    <= (job.left == EW'(1)) ? MV_IDLE : MV_READ;
                end
                default: state <= MV_IDLE;
            endcase
        end
    end

    assign idle        = (state == MV_IDLE);
    assign frame_done  = (state == MV_WRITE) && (job.left == EW'(1));
    assign cur_ch      = job.ch;
    assign nxt_src     = job.src;
    assign nxt_dst     = job.dst + STEP;
    assign mem_rd_en   = (state == MV_READ);
    assign mem_rd_addr = job.src;
    assign mem_wr_en   = (state == MV_WRITE);
    assign mem_wr_addr = job.dst;
    assign mem_wr_data = mem_rd_data;
endmodule

// File: rtl/dual_chain_dma.sv
module dual_chain_dma
    import dcd_pkg::*;
#(
    parameter int NCH = 2,
    parameter int AW  = 16,
    parameter int EW  = 8,
    parameter int FW  = 8,
    parameter int CIW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NCH-1:0][AW-1:0]   cfg_src,
    input  logic [NCH-1:0][AW-1:0]   cfg_dst,
    input  logic [NCH-1:0][EW-1:0]   cfg_ecnt,
    input  logic [NCH-1:0][FW-1:0]   cfg_fcnt,
    input  logic [NCH-1:0]           cfg_block,
    input  logic [NCH-1:0]           cfg_chain_en,
    input  logic [NCH-1:0][CIW-1:0]  cfg_chain_tgt,
    input  logic [NCH-1:0]           cfg_irq_en,
    input  logic [NCH-1:0]           sw_start,
    input  logic [NCH-1:0]           hw_req,
    input  logic [NCH-1:0]           flag_clr,
    output logic [NCH-1:0]           blk_done,
    output logic [NCH-1:0]           irq,
    output logic [NCH-1:0]           busy,
    output logic                     mem_rd_en,
    output logic [AW-1:0]            mem_rd_addr,
    input  logic [15:0]              mem_rd_data,
    output logic                     mem_wr_en,
    output logic [AW-1:0]            mem_wr_addr,
    output logic [15:0]              mem_wr_data
);
    logic [NCH-1:0]          ch_active, ch_pend, ch_done, ch_chain, ch_trig, ch_fdone;
    logic [NCH-1:0][AW-1:0]  ch_src, ch_dst;
    logic                    gnt_valid, mv_idle, mv_fdone;
    logic [CIW-1:0]          gnt_idx, mv_ch;
    logic [AW-1:0]           mv_src, mv_dst;

    always_comb begin
        ch_trig = '0;
        for (int t = 0; t < NCH; t++) begin
            for (int c = 0; c < NCH; c++) begin
                if (ch_chain[c] && cfg_chain_en[c] && (cfg_chain_tgt[c] == CIW'(t)))
                    ch_trig[t] = 1'b1;
            end
        end
    end

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_chan
            assign ch_fdone[g] = mv_fdone && (mv_ch == CIW'(g));
            dcd_chan #(.AW(AW), .EW(EW), .FW(FW)) u_chan (
                .clk        (clk),
                .rst        (rst),
                .start      (sw_start[g] | ch_trig[g]),
                .hw_req     (hw_req[g]),
                .flag_clr   (flag_clr[g]),
                .cfg_src    (cfg_src[g]),
                .cfg_dst    (cfg_dst[g]),
                .cfg_ecnt   (cfg_ecnt[g]),
                .cfg_fcnt   (cfg_fcnt[g]),
                .cfg_block  (cfg_block[g]),
                .frame_done (ch_fdone[g]),
                .upd_src    (mv_src),
                .upd_dst    (mv_dst),
                .active     (ch_active[g]),
                .pend       (ch_pend[g]),
                .cur_src    (ch_src[g]),
                .cur_dst    (ch_dst[g]),
                .done_flag  (ch_done[g]),
                .chain_fire (ch_chain[g])
            );
        end
    endgenerate

    dcd_arb #(.NCH(NCH), .CIW(CIW)) u_arb (
        .pend      (ch_pend),
        .gnt_valid (gnt_valid),
        .gnt_idx   (gnt_idx)
    );

    dcd_mover #(.AW(AW), .EW(EW), .CIW(CIW)) u_mover (
        .clk         (clk),
        .rst         (rst),
        .load        (gnt_valid && mv_idle),
        .ld_ch       (gnt_idx),
        .ld_src      (ch_src[gnt_idx]),
        .ld_dst      (ch_dst[gnt_idx]),
        .ld_ecnt     (cfg_ecnt[gnt_idx]),
        .idle        (mv_idle),
        .frame_done  (mv_fdone),
        .cur_ch      (mv_ch),
        .nxt_src     (mv_src),
        .nxt_dst     (mv_dst),
        .mem_rd_en   (mem_rd_en),
        .mem_rd_addr (mem_rd_addr),
        .mem_rd_data (mem_rd_data),
        .mem_wr_en   (mem_wr_en),
        .mem_wr_addr (mem_wr_addr),
        .mem_wr_data (mem_wr_data)
    );

    assign blk_done = ch_done;
    assign irq      = ch_done & cfg_irq_en;
    assign busy     = ch_active;
endmodule

// File: rtl/dcd_check.sv
module dcd_check #(
    parameter int NCH = 2,
    parameter int AW  = 16
) (
    input logic           clk,
    input logic           rst,
    input logic [NCH-1:0] blk_done,
    input logic [NCH-1:0] busy,
    input logic [NCH-1:0] flag_clr,
    input logic           mem_rd_en,
    input logic           mem_wr_en,
    input logic [AW-1:0]  mem_wr_addr,
    input logic [AW-1:0]  mem_rd_addr
);
    AST_WR_FOLLOWS_RD: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |-> $past(mem_rd_en)); // R10

    AST_NO_RD_WR_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd_en && mem_wr_en)); // R10

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (($past(blk_done) & ~$past(flag_clr) & ~blk_done) == '0)); // R3

    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_en |-> !mem_wr_addr[0]) and (mem_rd_en |-> !mem_rd_addr[0])); // R1

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_chk
            AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
                $rose(blk_done[g]) |-> !busy[g]); // R11
        end
    endgenerate
endmodule

bind dual_chain_dma dcd_check #(.NCH(NCH), .AW(AW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .blk_done    (blk_done),
    .busy        (busy),
    .flag_clr    (flag_clr),
    .mem_rd_en   (mem_rd_en),
    .mem_wr_en   (mem_wr_en),
    .mem_wr_addr (mem_wr_addr),
    .mem_rd_addr (mem_rd_addr)
);

// File: tb/dual_chain_dma_tb.sv
module dual_chain_dma_tb;
    localparam int CLK_PERIOD = 10;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [1:0][15:0] cfg_src, cfg_dst;
    logic [1:0][7:0]  cfg_ecnt, cfg_fcnt;
    logic [1:0]       cfg_block, cfg_chain_en, cfg_irq_en;
    logic [1:0][0:0]  cfg_chain_tgt;
    logic [1:0]       sw_start, hw_req, flag_clr;
    logic [1:0]       blk_done, irq, busy;
    logic             mem_rd_en, mem_wr_en;
    logic [15:0]      mem_rd_addr, mem_wr_addr, mem_rd_data, mem_wr_data;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [15:0] mem [512];
    bit clear_req = 1'b0;
    int wr_total = 0;
    int cyc = 0;
    int first_mid, last_mid, first_hi, last_hi;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_chain_dma u_dut (
        .clk(clk), .rst(rst),
        .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_ecnt(cfg_ecnt), .cfg_fcnt(cfg_fcnt),
        .cfg_block(cfg_block), .cfg_chain_en(cfg_chain_en), .cfg_chain_tgt(cfg_chain_tgt),
        .cfg_irq_en(cfg_irq_en), .sw_start(sw_start), .hw_req(hw_req), .flag_clr(flag_clr),
        .blk_done(blk_done), .irq(irq), .busy(busy),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
    );

    // memory model: words 0..63 hold 16'hA000+index, the rest start at zero
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (clear_req) begin
            for (int i = 0; i < 512; i++) mem[i] <= (i < 64) ? 16'(16'hA000 + i) : 16'h0000;
            first_mid <= -1; last_mid <= -1; first_hi <= -1; last_hi <= -1;
        end else begin
            if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr[9:1]];
            if (mem_wr_en) begin
                mem[mem_wr_addr[9:1]] <= mem_wr_data;
                wr_total <= wr_total + 1;
                if (mem_wr_addr >= 16'h0200) begin
                    if (first_hi < 0) first_hi <= cyc;
                    last_hi <= cyc;
                end else if (mem_wr_addr >= 16'h0100) begin
                    if (first_mid < 0) first_mid <= cyc;
                    last_mid <= cyc;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        @(negedge clk); clear_req = 1'b1;
        @(negedge clk); clear_req = 1'b0;
    endtask

    task automatic set_ch(input int c, input logic [15:0] s, input logic [15:0] d,
                          input int e, input int f, input bit blk, input bit ce, input bit tg);
        cfg_src[c] = s; cfg_dst[c] = d; cfg_ecnt[c] = 8'(e); cfg_fcnt[c] = 8'(f);
        cfg_block[c] = blk; cfg_chain_en[c] = ce; cfg_chain_tgt[c] = tg;
    endtask

    task automatic pulse_start(input logic [1:0] m);
        @(negedge clk); sw_start = m;
        @(negedge clk); sw_start = '0;
    endtask

    task automatic pulse_req(input logic [1:0] m);
        @(negedge clk); hw_req = m;
        @(negedge clk); hw_req = '0;
    endtask

    task automatic pulse_clr(input logic [1:0] m);
        @(negedge clk); flag_clr = m;
        @(negedge clk); flag_clr = '0;
    endtask

    task automatic wait_idle();
        int q = 0;
        for (int i = 0; i < 3000 && q < 6; i++) begin
            @(negedge clk);
            if (busy == 2'b00) q++; else q = 0;
        end
    endtask

    function automatic int region_bad(input int dword, input int sword, input int n);
        int bad = 0;
        for (int k = 0; k < n; k++)
            if (mem[dword + k] !== 16'(16'hA000 + sword + k)) bad++;
        return bad;
    endfunction

    initial begin
        int base;
        cfg_src = '0; cfg_dst = '0; cfg_ecnt = '0; cfg_fcnt = '0; cfg_block = '0;
        cfg_chain_en = '0; cfg_chain_tgt = '0; cfg_irq_en = '0;
        sw_start = '0; hw_req = '0; flag_clr = '0;
        clear_req = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0; clear_req = 1'b0;
        @(negedge clk);
        chk(blk_done == 2'b00, "R3 reset flags", blk_done, 0);
        chk(busy == 2'b00, "R11 reset busy", busy, 0);
        chk(irq == 2'b00 && !mem_wr_en, "R3 reset irq", irq, 0);

        // sweep of block-mode sizes on channel 0 (covers zero counts)
        cfg_irq_en = 2'b01;
        for (int e = 0; e < 4; e++) begin
            for (int f = 0; f < 4; f++) begin
                clear_mem();
                set_ch(0, 16'h0000, 16'h0100, e, f, 1'b1, 1'b0, 1'b0);
                base = wr_total;
                pulse_start(2'b01);
                wait_idle();
                chk(blk_done[0], "R9/R1 flag set", blk_done[0], 1);
                chk(wr_total - base == e * f, "R1 write count (R9 when zero)", wr_total - base, e * f);
                chk(region_bad(128, 0, e * f) == 0, "R1 data copy", region_bad(128, 0, e * f), 0);
                chk(mem[128 + e * f] == 16'h0, "R1 no overrun", mem[128 + e * f], 0);
                chk(irq[0] == 1'b1, "R3 irq enabled", irq[0], 1);
                pulse_clr(2'b01);
                chk(blk_done[0] == 1'b0 && irq[0] == 1'b0, "R3 cleared", blk_done[0], 0);
            end
        end
        cfg_irq_en = 2'b00;

        // busy and sticky flag across restart, address reload
        clear_mem();
        set_ch(0, 16'h0000, 16'h0100, 3, 3, 1'b1, 1'b0, 1'b0);
        pulse_start(2'b01);
        chk(busy[0] == 1'b1, "R11 busy after start", busy[0], 1);
        chk(irq[0] == 1'b0, "R3 irq masked", irq[0], 0);
        wait_idle();
        base = wr_total;
        pulse_start(2'b01);
        chk(blk_done[0] == 1'b1, "R3 flag kept on restart", blk_done[0], 1);
        wait_idle();
        chk(wr_total - base == 9, "R7 second run count", wr_total - base, 9);
        chk(mem[128 + 9] == 16'h0 && region_bad(128, 0, 9) == 0, "R7 reload same region", mem[137], 0);
        pulse_clr(2'b01);

        // frame mode: idle request ignored, one frame per request, start ignored while busy
        clear_mem();
        set_ch(0, 16'h0000, 16'h0100, 2, 3, 1'b0, 1'b0, 1'b0);
        base = wr_total;
        pulse_req(2'b01);
        repeat (10) @(negedge clk);
        chk(wr_total == base, "R2 idle request ignored", wr_total - base, 0);
        pulse_start(2'b01);
        repeat (15) @(negedge clk);
        chk(wr_total - base == 2, "R2 first frame only", wr_total - base, 2);
        chk(busy[0] == 1'b1, "R2 waits for request", busy[0], 1);
        pulse_start(2'b01);
        repeat (10) @(negedge clk);
        chk(wr_total - base == 2, "R6 start while busy moves nothing", wr_total - base, 2);
        pulse_req(2'b01);
        repeat (15) @(negedge clk);
        chk(wr_total - base == 4, "R2 second frame", wr_total - base, 4);
        pulse_req(2'b01);
        wait_idle();
        chk(wr_total - base == 6 && blk_done[0], "R2 all frames", wr_total - base, 6);
        chk(region_bad(128, 0, 6) == 0, "R6 no reload, contiguous", region_bad(128, 0, 6), 0);
        pulse_clr(2'b01);

        // frame-mode chain: target runs after every frame
        clear_mem();
        set_ch(0, 16'h0000, 16'h0100, 2, 3, 1'b0, 1'b1, 1'b1);
        set_ch(1, 16'h0040, 16'h0200, 2, 1, 1'b1, 1'b0, 1'b0);
        base = wr_total;
        pulse_start(2'b01);
        repeat (20) @(negedge clk);
        chk(blk_done[1] == 1'b1 && busy[0] == 1'b1, "R4 target done after first frame", blk_done[1], 1);
        chk(wr_total - base == 4, "R4 writes after first frame", wr_total - base, 4);
        pulse_req(2'b01);
        repeat (20) @(negedge clk);
        pulse_req(2'b01);
        wait_idle();
        chk(wr_total - base == 12, "R4 target ran per frame", wr_total - base, 12);
        chk(region_bad(256, 32, 2) == 0, "R4 target data", region_bad(256, 32, 2), 0);
        pulse_clr(2'b11);

        // block-mode chain: target only after last frame
        clear_mem();
        set_ch(0, 16'h0000, 16'h0100, 2, 2, 1'b1, 1'b1, 1'b1);
        set_ch(1, 16'h0040, 16'h0200, 2, 1, 1'b1, 1'b0, 1'b0);
        base = wr_total;
        pulse_start(2'b01);
        wait_idle();
        chk(first_hi > last_mid, "R5 target after whole block", first_hi, last_mid + 1);
        chk(wr_total - base == 6 && blk_done == 2'b11, "R5 counts", wr_total - base, 6);
        pulse_clr(2'b11);

        // zero count still chains
        clear_mem();
        set_ch(0, 16'h0000, 16'h0100, 2, 0, 1'b1, 1'b1, 1'b1);
        set_ch(1, 16'h0040, 16'h0200, 1, 1, 1'b1, 1'b0, 1'b0);
        base = wr_total;
        pulse_start(2'b01);
        wait_idle();
        chk(blk_done == 2'b11 && wr_total - base == 1, "R9 zero count chains", wr_total - base, 1);
        pulse_clr(2'b11);

        // priority: both started together, channel 0 first
        clear_mem();
        set_ch(0, 16'h0000, 16'h0100, 2, 2, 1'b1, 1'b0, 1'b0);
        set_ch(1, 16'h0040, 16'h0200, 3, 1, 1'b1, 1'b0, 1'b0);
        pulse_start(2'b11);
        wait_idle();
        chk(first_mid < first_hi, "R8 channel 0 first", first_mid, first_hi - 1);
        pulse_clr(2'b11);

        // no pre-emption: channel 1 frame finishes before channel 0 writes
        clear_mem();
        pulse_start(2'b10);
        pulse_start(2'b01);
        wait_idle();
        chk(last_hi < first_mid, "R8 frame not pre-empted", last_hi, first_mid - 1);
        chk(region_bad(256, 32, 3) == 0 && region_bad(128, 0, 4) == 0, "R8 both copies", 0, 0);
        pulse_clr(2'b11);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule